// File: doc/BRIEF.md
# Quad Wiper Register Bank with Recall

This block holds the tap settings of four resistor-ladder channels. Each channel owns one volatile wiper register, whose value picks the active tap, and four data registers that stand in for persistent storage. A serial front end turns host traffic into single-cycle commands on a parallel command port. Each command names an operation, a channel and a register. The operations read and write the wiper, read and write a data register, and copy a value between a data register and the wiper in either direction.

The data registers are flops loaded with factory values at reset. A write to a data register takes a persistent-write time of `WR_CYCLES` clocks. The busy output stays high for that whole time, and every command issued during it is dropped. In the first cycle after reset each wiper recalls its channel's register 0 (busy is high in that cycle as well). An active-low write-protect input blocks every persistent write and leaves wiper writes alone. Each wiper is also decoded into a one-hot tap-select vector.

Top module: `wiper_bank`

## Requirements
- R1: In the first cycle after reset busy_o is high and the block takes no command. From the second cycle each wiper equals its channel's register 0. Data register r of channel c resets to ((c*4 + r)*37 + 11) mod 256.
- R2: Opcode 0 (read wiper) is accepted when cmd_valid_i is high and busy_o is low. One cycle later it drives rd_valid_o high for exactly one cycle, with rd_data_o equal to the selected channel's wiper.
- R3: Opcode 2 (read data register) returns the register picked by cmd_ch_i/cmd_reg_i, with the same timing as R2.
- R4: Opcode 1 (write wiper) loads cmd_data_i into the selected wiper on the next clock, whatever the level of wp_ni.
- R5: Opcode 3 (write data register) accepted with wp_ni high raises busy_o from the next cycle for exactly WR_CYCLES cycles. The register holds the new value once busy_o falls.
- R6: With wp_ni low, opcodes 3 and 5 raise no busy and leave every data register unchanged.
- R7: Opcode 4 loads the selected data register into the selected wiper on the next clock, whatever the level of wp_ni.
- R8: Opcode 5 (wiper to data register) with wp_ni high is a persistent write, timed as in R5. It stores the wiper value the channel held when the command was accepted.
- R9: While busy_o is high, every command is ignored: no read response, no wiper change, no register change.
- R10: tap_sel_o[c*256 +: 256] is one-hot, and its set bit is at the index equal to wiper c (wiper_o[c*8 +: 8]).
- R11: Opcodes 6 and 7 change no register, raise no busy and return no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Operation code |
| cmd_ch_i | input | 2 | Channel index |
| cmd_reg_i | input | 2 | Data register index |
| cmd_data_i | input | 8 | Write data |
| wp_ni | input | 1 | Write protect, low blocks persistent writes |
| busy_o | output | 1 | Recall or persistent write in progress |
| rd_valid_o | output | 1 | Read response strobe |
| rd_data_o | output | 8 | Read response data |
| wiper_o | output | 32 | Four wiper values, channel c at [c*8 +: 8] |
| tap_sel_o | output | 1024 | Four one-hot tap selects, channel c at [c*256 +: 256] |

## Verification
On every cycle the assertions check the following. Each tap vector is one-hot and matches its wiper. A wiper write lands on the next clock. Read strobes follow accepted reads and never follow a busy cycle. Write protect suppresses busy. A wiper never moves while a persistent write is pending. Data register contents are visible only through reads. So the exact busy length, the deferred commit of data-register writes, the power-up recall, the factory reset values and the silence of the undefined opcodes are shown only by the bench's sweeps. The bench reads every register back after those scenarios.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;
  typedef enum logic [2:0] {
    OP_RD_WCR = 3'd0,
    OP_WR_WCR = 3'd1,
    OP_RD_DR  = 3'd2,
    OP_WR_DR  = 3'd3,
    OP_DR2WCR = 3'd4,
    OP_WCR2DR = 3'd5
  } op_e;

  // factory contents of data register r of channel c
  function automatic int dr_init(int c, int r, int nreg);
    return ((c * nreg + r) * 37 + 11) % 256;
  endfunction
endpackage

// File: rtl/wb_nv_timer.sv
module wb_nv_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNTW = $clog2(CYCLES + 1);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CNTW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNTW'(1));
endmodule

// File: rtl/wb_channel.sv
module wb_channel #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  parameter int CH   = 0,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 boot_i,
  input  logic                 wcr_we_i,
  input  logic [DW-1:0]        wcr_d_i,
  input  logic                 dr_we_i,
  input  logic [RW-1:0]        dr_sel_i,
  input  logic [DW-1:0]        dr_d_i,
  output logic [DW-1:0]        wcr_o,
  output logic [NREG*DW-1:0]   dr_o
);
  logic [NREG-1:0][DW-1:0] dr_q;
  logic [DW-1:0]           wcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++)
        dr_q[r] <= DW'(wiper_bank_pkg::dr_init(CH, r, NREG));
    end else if (dr_we_i) begin
      dr_q[dr_sel_i] <= dr_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wcr_q <= '0;
    else if (boot_i)   wcr_q <= dr_q[0];
    else if (wcr_we_i) wcr_q <= wcr_d_i;
  end

  assign wcr_o = wcr_q;
  assign dr_o  = dr_q;
endmodule

// File: rtl/wb_tap_decode.sv
module wb_tap_decode #(
  parameter int DW  = 8,
  localparam int NT = 1 << DW
) (
  input  logic [DW-1:0] wcr_i,
  output logic [NT-1:0] tap_o
);
  always_comb begin
    tap_o        = '0;
    tap_o[wcr_i] = 1'b1;
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_bank_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int NREG      = 4,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 16,
  localparam int CW       = $clog2(NCH),
  localparam int RW       = $clog2(NREG),
  localparam int NT       = 1 << DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [CW-1:0]     cmd_ch_i,
  input  logic [RW-1:0]     cmd_reg_i,
  input  logic [DW-1:0]     cmd_data_i,
  input  logic              wp_ni,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic [NCH*DW-1:0] wiper_o,
  output logic [NCH*NT-1:0] tap_sel_o
);
  op_e                  op;
  logic                 boot_q, accept, nv_start, nv_busy, nv_done, is_rd;
  logic [DW-1:0]        wcr_vec [NCH];
  logic [NREG*DW-1:0]   dr_flat [NCH];
  logic [DW-1:0]        wcr_sel, dr_sel;
  logic [CW-1:0]        pend_ch_q;
  logic [RW-1:0]        pend_reg_q;
  logic [DW-1:0]        pend_data_q;
  logic                 rd_valid_q;
  logic [DW-1:0]        rd_data_q;

  assign op       = op_e'(cmd_op_i);
  assign busy_o   = boot_q | nv_busy;
  assign accept   = cmd_valid_i & ~busy_o;
  assign nv_start = accept & wp_ni & ((op == OP_WR_DR) | (op == OP_WCR2DR));
  assign is_rd    = (op == OP_RD_WCR) | (op == OP_RD_DR);
  assign wcr_sel  = wcr_vec[cmd_ch_i];
  assign dr_sel   = dr_flat[cmd_ch_i][int'(cmd_reg_i)*DW +: DW];

  // recall cycle after power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else         boot_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ch_q   <= '0;
      pend_reg_q  <= '0;
      pend_data_q <= '0;
    end else if (nv_start) begin
      pend_ch_q   <= cmd_ch_i;
      pend_reg_q  <= cmd_reg_i;
      pend_data_q <= (op == OP_WR_DR) ? cmd_data_i : wcr_sel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= accept & is_rd;
      if (accept & is_rd) rd_data_q <= (op == OP_RD_WCR) ? wcr_sel : dr_sel;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  wb_nv_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(nv_start),
    .busy_o (nv_busy),
    .done_o (nv_done)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wcr_we;
    logic dr_we;
    assign wcr_we = accept & (cmd_ch_i == CW'(c)) &
                    ((op == OP_WR_WCR) | (op == OP_DR2WCR));
    assign dr_we  = nv_done & (pend_ch_q == CW'(c));

    wb_channel #(.DW(DW), .NREG(NREG), .CH(c)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .boot_i  (boot_q),
      .wcr_we_i(wcr_we),
      .wcr_d_i ((op == OP_WR_WCR) ? cmd_data_i : dr_sel),
      .dr_we_i (dr_we),
      .dr_sel_i(pend_reg_q),
      .dr_d_i  (pend_data_q),
      .wcr_o   (wcr_vec[c]),
      .dr_o    (dr_flat[c])
    );

    wb_tap_decode #(.DW(DW)) u_dec (
      .wcr_i(wcr_vec[c]),
      .tap_o(tap_sel_o[c*NT +: NT])
    );

    assign wiper_o[c*DW +: DW] = wcr_vec[c];
  end
endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
  parameter int NCH  = 4,
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int CW  = $clog2(NCH),
  localparam int RW  = $clog2(NREG),
  localparam int NT  = 1 << DW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [CW-1:0]     cmd_ch_i,
  input logic [RW-1:0]     cmd_reg_i,
  input logic [DW-1:0]     cmd_data_i,
  input logic              wp_ni,
  input logic              busy_o,
  input logic              rd_valid_o,
  input logic [NCH*DW-1:0] wiper_o,
  input logic [NCH*NT-1:0] tap_sel_o,
  input logic              nv_busy
);
  logic acc;
  assign acc = cmd_valid_i && !busy_o;

  p_rd_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (cmd_op_i == 3'd0 || cmd_op_i == 3'd2) |=> rd_valid_o);

  p_no_rd_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o);

  p_wp_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !wp_ni && (cmd_op_i == 3'd3 || cmd_op_i == 3'd5) |=> !busy_o);

  p_nv_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && wp_ni && cmd_op_i == 3'd3 |=> busy_o);

  p_wiper_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_busy |=> $stable(wiper_o));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_wcr_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc && cmd_op_i == 3'd1 && cmd_ch_i == CW'(c)
      |=> wiper_o[c*DW +: DW] == $past(cmd_data_i));

    p_tap_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(tap_sel_o[c*NT +: NT]));

    p_tap_pos_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_sel_o[c*NT + int'(wiper_o[c*DW +: DW])]);
  end
endmodule

bind wiper_bank wb_checker #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_ch_i   (cmd_ch_i),
  .cmd_reg_i  (cmd_reg_i),
  .cmd_data_i (cmd_data_i),
  .wp_ni      (wp_ni),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .wiper_o    (wiper_o),
  .tap_sel_o  (tap_sel_o),
  .nv_busy    (nv_busy)
);

// File: tb/sim_wiper_bank.sv
`timescale 1ns/1ps
module sim_wiper_bank;
  localparam int WRC = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [1:0]   cmd_ch = '0;
  logic [1:0]   cmd_reg = '0;
  logic [7:0]   cmd_data = '0;
  logic         wp_n = 1'b1;
  logic         busy, rd_valid;
  logic [7:0]   rd_data;
  logic [31:0]  wiper;
  logic [1023:0] tap;

  int vecs = 0;
  int errs = 0;
  int mdr [4][4];
  int mwcr [4];

  always #4 clk = ~clk;

  wiper_bank #(.WR_CYCLES(WRC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_ch_i(cmd_ch), .cmd_reg_i(cmd_reg), .cmd_data_i(cmd_data), .wp_ni(wp_n),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .wiper_o(wiper), .tap_sel_o(tap)
  );

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the accepting posedge
  task automatic issue(int op, int ch, int rg, int d, bit wp);
    cmd_valid = 1'b1;
    cmd_op = 3'(op); cmd_ch = 2'(ch); cmd_reg = 2'(rg); cmd_data = 8'(d); wp_n = wp;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wp_n = 1'b1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_wiper(string req, int c);
    check(req, int'(wiper[c*8 +: 8]), mwcr[c]);
    check({req, " tap count"}, $countones(tap[c*256 +: 256]), 1);
    check({req, " tap bit"}, int'(tap[c*256 + mwcr[c]]), 1);
  endtask

  task automatic read_dr(string req, int c, int r);
    issue(2, c, r, 0, 1'b1);
    check({req, " rd_valid"}, int'(rd_valid), 1);
    check(req, int'(rd_data), mdr[c][r]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) mdr[c][r] = ((c * 4 + r) * 37 + 11) % 256;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check("R1 boot busy", int'(busy), 1);
    check("R1 no rd", int'(rd_valid), 0);
    @(negedge clk);
    check("R1 busy clear", int'(busy), 0);
    for (int c = 0; c < 4; c++) begin
      mwcr[c] = mdr[c][0];
      check_wiper("R1 recall R10", c);
    end

    // R3 R1 factory contents
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) read_dr("R3 R1 init", c, r);

    // R2 wiper reads
    for (int c = 0; c < 4; c++) begin
      issue(0, c, 0, 0, 1'b1);
      check("R2 rd_valid", int'(rd_valid), 1);
      check("R2 rd_data", int'(rd_data), mwcr[c]);
      @(negedge clk);
      check("R2 single pulse", int'(rd_valid), 0);
    end

    // R4 R10 full wiper sweep, WP toggled
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 256; v++) begin
        issue(1, c, 0, v, v[0]);
        mwcr[c] = v;
        check_wiper("R4 R10 sweep", c);
        check("R4 no busy", int'(busy), 0);
      end

    // R5 persistent writes
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        int v = (c * 16 + r * 5 + 90) % 256;
        issue(3, c, r, v, 1'b1);
        wait_idle(n);
        check("R5 busy length", n, WRC);
        mdr[c][r] = v;
        read_dr("R5 readback", c, r);
      end

    // R6 write protect
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        issue(3, c, r, 255 - mdr[c][r], 1'b0);
        check("R6 no busy wr", int'(busy), 0);
        issue(5, c, r, 0, 1'b0);
        check("R6 no busy copy", int'(busy), 0);
        read_dr("R6 unchanged", c, r);
      end

    // R7 data register to wiper, WP irrelevant
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        issue(4, c, r, 0, r[0]);
        mwcr[c] = mdr[c][r];
        check_wiper("R7 copy", c);
      end

    // R8 wiper to data register
    for (int c = 0; c < 4; c++) begin
      int v = (c * 71 + 3) % 256;
      int r = (c + 1) % 4;
      issue(1, c, 0, v, 1'b1);
      mwcr[c] = v;
      issue(5, c, r, 200, 1'b1);
      issue(1, c, 0, 0, 1'b1);  // dropped while busy
      check_wiper("R8 R9 wiper held", c);
      wait_idle(n);
      check("R8 busy length", n + 1, WRC);
      mdr[c][r] = v;
      read_dr("R8 stored", c, r);
    end

    // R9 commands ignored while busy
    issue(3, 2, 3, 17, 1'b1);
    issue(0, 2, 0, 0, 1'b1);
    check("R9 no read", int'(rd_valid), 0);
    issue(4, 1, 0, 0, 1'b1);
    check_wiper("R9 no copy", 1);
    issue(3, 0, 0, 99, 1'b1);
    wait_idle(n);
    check("R9 busy length", n + 3, WRC);
    mdr[2][3] = 17;
    read_dr("R9 first write kept", 2, 3);
    read_dr("R9 second write dropped", 0, 0);

    // R11 undefined opcodes
    for (int op = 6; op < 8; op++)
      for (int c = 0; c < 4; c++) begin
        issue(op, c, c, 123, 1'b1);
        check("R11 no busy", int'(busy), 0);
        check("R11 no read", int'(rd_valid), 0);
        check_wiper("R11 wiper", c);
        read_dr("R11 data", c, c);
      end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule